// File: doc/BRIEF.md
# Control-Flow Execution Unit

This unit is the branching stage of a small processor that runs each instruction in three steps: fetch, decode and execute. It holds the 24-bit program counter (PC) and the 24-bit stack pointer (SP). It advances through its phases on a step strobe from the fetch side. It adds 4 to the PC on each fetch step and latches the instruction word on the decode step. On the execute step it carries out one of these: a jump (always or on a flag), a call (always or on a flag), a return, a load of SP from an immediate, or a no-operation. The flag input is only read, never written.

Calls and returns use a single-port stack memory with synchronous read and write, addressed through `stk_addr`. A taken call stores the PC of the following instruction at SP and moves SP up by 6. A return moves SP down by 6 and reloads the PC from that slot one clock later. A fault sets a 3-bit status code, and the unit then freezes until reset.

The control states are FETCH, DECODE, EXEC, RETWAIT and HALT.
- FETCH goes to DECODE on step.
- DECODE goes to EXEC on step, or to HALT on step when the opcode is unknown.
- EXEC goes to FETCH on step. It goes to RETWAIT on step for a return, and to HALT on step for a stack or immediate fault.
- RETWAIT goes to FETCH after one clock with no step needed.
- HALT holds until reset.

Top module: `flow_ctl_unit`

## Requirements
- R1: `phase` reads 0 in FETCH, 1 in DECODE, 2 in EXEC and RETWAIT, and 3 in HALT. The phase moves on only on a clock with `step` high, except that RETWAIT always leaves after one clock. After EXEC the unit returns to FETCH.
- R2: A step in FETCH adds 4 to the PC.
- R3: The opcode is `instr[28:24]` and the target is `instr[23:0]`. Opcodes 0x01 to 0x05 are jumps with these conditions: 0x01 always, 0x02 on zero set, 0x03 on zero clear, 0x04 on carry set, 0x05 on carry clear. The zero flag is `flags[0]` and the carry flag is `flags[1]`. A taken jump loads the target into the PC. A jump whose condition is false leaves the PC alone. Bits 31:29 do not affect a jump.
- R4: Opcodes 0x11 to 0x15 are calls with the same conditions as 0x01 to 0x05. A taken call writes the PC to stack address SP in one write, adds 6 to SP and loads the target into the PC. A call whose condition is false changes nothing.
- R5: Opcode 0x10 is a return. On the execute step it subtracts 6 from SP and reads the stack at the new SP. The PC takes the value read on the following clock.
- R6: Opcode 0x0F loads the target into SP. If `instr[31:29]` is non-zero, SP keeps its value and the status becomes 4.
- R7: Opcode 0x00 changes nothing. Any other opcode that R3 to R6 do not list sets status 2 on the decode step.
- R8: A taken call when SP is above 0xFFFFF9, or a return when SP is below 6, sets status 1 and leaves PC, SP and the stack unchanged.
- R9: Status 0 means no fault. A non-zero status holds until reset. While it is non-zero, `phase` is 3, PC and SP do not change and the stack is not written.
- R10: A synchronous active-high reset clears PC, SP, phase and status to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | Advance strobe from the fetch side |
| instr | input | 32 | Instruction word, sampled on the decode step |
| flags | input | 2 | Flag register: bit 0 zero, bit 1 carry |
| stk_addr | output | 24 | Stack memory address |
| stk_we | output | 1 | Stack memory write enable |
| stk_wdata | output | 24 | Return address being pushed |
| stk_rdata | input | 24 | Stack read data, valid one clock after the address |
| pc | output | 24 | Program counter |
| sp | output | 24 | Stack pointer |
| phase | output | 2 | Current phase code |
| status | output | 3 | Fault code: 0 ok, 1 stack range, 2 unknown opcode, 4 bad immediate |

## Verification
A wrong PC update or a wrong condition decode shows on `pc` at the first clock after the execute step. An SP off by anything other than the stride shows on `sp` at the same clock. A wrong pushed address or value stays hidden until the matching return, which can be several instructions later. The bench therefore checks the stack slots directly and runs nested call and return pairs. A state that enters the wrong successor shows on `phase` within one step. A fault that is not latched shows on `status` and as motion that continues after the fault.

// File: rtl/fcu_pkg.sv
package fcu_pkg;
    localparam int OPC_W = 5;

    typedef enum logic [2:0] {K_NOP, K_JUMP, K_CALL, K_RET, K_SPLD, K_BAD} kind_e;
    typedef enum logic [2:0] {C_ALWAYS, C_ZSET, C_ZCLR, C_CSET, C_CCLR, C_NEVER} cond_e;
    typedef enum logic [2:0] {ST_FETCH, ST_DECODE, ST_EXEC, ST_RETWAIT, ST_HALT} state_e;

    localparam logic [2:0] STAT_OK   = 3'd0;
    localparam logic [2:0] STAT_EXEC = 3'd1;
    localparam logic [2:0] STAT_DEC  = 3'd2;
    localparam logic [2:0] STAT_INT  = 3'd4;
endpackage

// File: rtl/fcu_decode.sv
module fcu_decode
    import fcu_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    output kind_e            kind,
    output cond_e            cond
);
    // Low four opcode bits pick the condition, bit 4 selects call over jump (R3, R4)
    always_comb begin
        kind = K_BAD;
        cond = C_NEVER;
        if (opc == 5'h00) begin
            kind = K_NOP;
        end else if (opc == 5'h0F) begin
            kind = K_SPLD;
        end else if (opc == 5'h10) begin
            kind = K_RET;
        end else if (opc[3:0] >= 4'h1 && opc[3:0] <= 4'h5) begin
            kind = opc[4] ? K_CALL : K_JUMP;
            case (opc[2:0])
                3'd1:    cond = C_ALWAYS;
                3'd2:    cond = C_ZSET;
                3'd3:    cond = C_ZCLR;
                3'd4:    cond = C_CSET;
                3'd5:    cond = C_CCLR;
                default: cond = C_NEVER;
            endcase
        end
    end
endmodule

// File: rtl/fcu_cond.sv
module fcu_cond
    import fcu_pkg::*;
#(
    parameter int ZBIT = 0,
    parameter int CBIT = 1
) (
    input  cond_e      cond,
    input  logic [1:0] flags,
    output logic       taken
);
    always_comb begin
        unique case (cond)
            C_ALWAYS: taken = 1'b1;
            C_ZSET:   taken = flags[ZBIT];
            C_ZCLR:   taken = !flags[ZBIT];
            C_CSET:   taken = flags[CBIT];
            C_CCLR:   taken = !flags[CBIT];
            default:  taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/flow_ctl_unit.sv
module flow_ctl_unit
    import fcu_pkg::*;
#(
    parameter int AW     = 24,
    parameter int IW     = 32,
    parameter int STRIDE = 6,
    parameter int PC_INC = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic [IW-1:0] instr,
    input  logic [1:0]    flags,
    output logic [AW-1:0] stk_addr,
    output logic          stk_we,
    output logic [AW-1:0] stk_wdata,
    input  logic [AW-1:0] stk_rdata,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] sp,
    output logic [1:0]    phase,
    output logic [2:0]    status
);
    localparam int            HI_W       = IW - OPC_W - AW;
    localparam logic [AW-1:0] SP_STEP    = AW'(STRIDE);
    localparam logic [AW-1:0] PC_STEP    = AW'(PC_INC);
    localparam logic [AW-1:0] CALL_LIMIT = {AW{1'b1}} - SP_STEP;

    state_e            state_q, state_d;
    kind_e             kind_q, dec_kind;
    cond_e             cond_q, dec_cond;
    logic [AW-1:0]     pc_q, sp_q, tgt_q;
    logic [HI_W-1:0]   hi_q;
    logic [2:0]        status_q;
    logic              taken, call_ovf, ret_unf, exec_fault;
    logic [2:0]        fault_code;

    fcu_decode u_dec (
        .opc  (instr[AW+OPC_W-1:AW]),
        .kind (dec_kind),
        .cond (dec_cond)
    );

    fcu_cond #(.ZBIT(0), .CBIT(1)) u_cond (
        .cond  (cond_q),
        .flags (flags),
        .taken (taken)
    );

    assign call_ovf   = sp_q > CALL_LIMIT;
    assign ret_unf    = sp_q < SP_STEP;
    assign exec_fault = (kind_q == K_CALL && taken && call_ovf)
                     || (kind_q == K_RET && ret_unf)
                     || (kind_q == K_SPLD && hi_q != '0);
    assign fault_code = (kind_q == K_SPLD) ? STAT_INT : STAT_EXEC;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH:   if (step) state_d = ST_DECODE;
            ST_DECODE:  if (step) state_d = (dec_kind == K_BAD) ? ST_HALT : ST_EXEC;
            ST_EXEC: begin
                if (step) begin
                    if (exec_fault)           state_d = ST_HALT;
                    else if (kind_q == K_RET) state_d = ST_RETWAIT;
                    else                      state_d = ST_FETCH;
                end
            end
            ST_RETWAIT: state_d = ST_FETCH;
            ST_HALT:    state_d = ST_HALT;
            default:    state_d = ST_HALT;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FETCH;
        else     state_q <= state_d;
    end

    // Architectural registers
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= '0;
            sp_q     <= '0;
            tgt_q    <= '0;
            hi_q     <= '0;
            kind_q   <= K_NOP;
            cond_q   <= C_NEVER;
            status_q <= STAT_OK;
        end else begin
            if (state_q == ST_FETCH && step) pc_q <= pc_q + PC_STEP;
            if (state_q == ST_DECODE && step) begin
                kind_q <= dec_kind;
                cond_q <= dec_cond;
                tgt_q  <= instr[AW-1:0];
                hi_q   <= instr[IW-1:AW+OPC_W];
                if (dec_kind == K_BAD) status_q <= STAT_DEC;
            end
            if (state_q == ST_EXEC && step) begin
                if (exec_fault) begin
                    status_q <= fault_code;
                end else begin
                    case (kind_q)
                        K_JUMP: if (taken) pc_q <= tgt_q;
                        K_CALL: if (taken) begin
                            pc_q <= tgt_q;
                            sp_q <= sp_q + SP_STEP;
                        end
                        K_RET:  sp_q <= sp_q - SP_STEP;
                        K_SPLD: sp_q <= tgt_q;
                        default: ;
                    endcase
                end
            end
            if (state_q == ST_RETWAIT) pc_q <= stk_rdata;
        end
    end

    // Outputs
    always_comb begin
        stk_addr  = (state_q == ST_EXEC && kind_q == K_RET) ? sp_q - SP_STEP : sp_q;
        stk_we    = (state_q == ST_EXEC) && step && (kind_q == K_CALL) && taken && !call_ovf;
        stk_wdata = pc_q;
        pc        = pc_q;
        sp        = sp_q;
        status    = status_q;
        unique case (state_q)
            ST_FETCH:   phase = 2'd0;
            ST_DECODE:  phase = 2'd1;
            ST_EXEC:    phase = 2'd2;
            ST_RETWAIT: phase = 2'd2;
            default:    phase = 2'd3;
        endcase
    end
endmodule

// File: rtl/flow_ctl_unit_chk.sv
module flow_ctl_unit_chk #(
    parameter int AW = 24
) (
    input logic          clk,
    input logic          rst,
    input logic          step,
    input logic [AW-1:0] pc,
    input logic [AW-1:0] sp,
    input logic [AW-1:0] stk_addr,
    input logic [AW-1:0] stk_wdata,
    input logic          stk_we,
    input logic [1:0]    phase,
    input logic [2:0]    status
);
    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> (pc == '0 && sp == '0 && phase == 2'd0 && status == 3'd0));

    a_r1_fetch_advance: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd0 && step) |=> phase == 2'd1);

    a_r1_hold_without_step: assert property (@(posedge clk) disable iff (rst)
        (!step && phase != 2'd2) |=> $stable(phase));

    a_r2_fetch_pc: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd0 && step) |=> pc == $past(pc) + AW'(4));

    a_r4_push_slot: assert property (@(posedge clk) disable iff (rst)
        stk_we |-> (stk_addr == sp && stk_wdata == pc));

    a_r4_call_stride: assert property (@(posedge clk) disable iff (rst)
        stk_we |=> sp == $past(sp) + AW'(6));

    a_r9_status_sticky: assert property (@(posedge clk) disable iff (rst)
        (status != 3'd0) |=> status == $past(status));

    a_r9_halt_quiet: assert property (@(posedge clk) disable iff (rst)
        (status != 3'd0) |-> (phase == 2'd3 && !stk_we));

    a_r9_halt_frozen: assert property (@(posedge clk) disable iff (rst)
        (status != 3'd0) |=> ($stable(pc) && $stable(sp)));
endmodule

bind flow_ctl_unit flow_ctl_unit_chk #(.AW(AW)) u_chk (.*);

// File: tb/flow_ctl_unit_bench.sv
`timescale 1ns/1ps
module flow_ctl_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step = 1'b0;
    logic [31:0] instr = '0;
    logic [1:0]  flags = '0;
    logic [23:0] stk_addr, stk_wdata, stk_rdata, pc, sp;
    logic        stk_we;
    logic [1:0]  phase;
    logic [2:0]  status;
    logic [23:0] mem [256];
    int          n_chk = 0;
    int          n_fail = 0;

    always #10 clk = ~clk;

    flow_ctl_unit u_flow_ctl_unit (
        .clk(clk), .rst(rst), .step(step), .instr(instr), .flags(flags),
        .stk_addr(stk_addr), .stk_we(stk_we), .stk_wdata(stk_wdata),
        .stk_rdata(stk_rdata), .pc(pc), .sp(sp), .phase(phase), .status(status)
    );

    // Stack memory model, one-clock synchronous read
    always @(posedge clk) begin
        if (stk_we) mem[stk_addr[7:0]] <= stk_wdata;
        stk_rdata <= mem[stk_addr[7:0]];
    end

    typedef struct packed {
        logic [31:0] ins;
        logic [1:0]  fl;
        logic [23:0] pc;
        logic [23:0] sp;
        logic [2:0]  st;
        logic [3:0]  req;
    } vec_t;

    // Each vector starts from reset: fetch leaves PC = 4, SP = 0
    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{32'h01000123, 2'd0, 24'h000123, 24'h0, 3'd0, 4'd3},  // R3 always
        '{32'h02000200, 2'd1, 24'h000200, 24'h0, 3'd0, 4'd3},  // R3 zero set, taken
        '{32'h02000200, 2'd0, 24'h000004, 24'h0, 3'd0, 4'd3},  // R3 zero set, not taken
        '{32'h03000300, 2'd0, 24'h000300, 24'h0, 3'd0, 4'd3},  // R3 zero clear, taken
        '{32'h03000300, 2'd1, 24'h000004, 24'h0, 3'd0, 4'd3},
        '{32'h04000400, 2'd2, 24'h000400, 24'h0, 3'd0, 4'd3},  // R3 carry set, taken
        '{32'h04000400, 2'd1, 24'h000004, 24'h0, 3'd0, 4'd3},
        '{32'h05000500, 2'd0, 24'h000500, 24'h0, 3'd0, 4'd3},  // R3 carry clear, taken
        '{32'h05000500, 2'd2, 24'h000004, 24'h0, 3'd0, 4'd3},
        '{32'hE1000777, 2'd0, 24'h000777, 24'h0, 3'd0, 4'd3},  // R3 upper bits ignored
        '{32'h11000AB0, 2'd3, 24'h000AB0, 24'h6, 3'd0, 4'd4},  // R4 always
        '{32'h12000AB0, 2'd0, 24'h000004, 24'h0, 3'd0, 4'd4},
        '{32'h13000AB0, 2'd1, 24'h000004, 24'h0, 3'd0, 4'd4},
        '{32'h14000AB0, 2'd2, 24'h000AB0, 24'h6, 3'd0, 4'd4},
        '{32'h15000AB0, 2'd2, 24'h000004, 24'h0, 3'd0, 4'd4},
        '{32'h00000000, 2'd3, 24'h000004, 24'h0, 3'd0, 4'd7},  // R7 no-op
        '{32'h0F00ABCD, 2'd0, 24'h000004, 24'hABCD, 3'd0, 4'd6}, // R6 load
        '{32'h2F000010, 2'd0, 24'h000004, 24'h0, 3'd4, 4'd6},  // R6 bad upper bits
        '{32'h06000000, 2'd0, 24'h000004, 24'h0, 3'd2, 4'd7},  // R7 unknown
        '{32'h1F000000, 2'd0, 24'h000004, 24'h0, 3'd2, 4'd7},  // R7 unknown
        '{32'h10000000, 2'd0, 24'h000004, 24'h0, 3'd1, 4'd8}   // R8 return below 6
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic pulse();
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_instr(input logic [31:0] w, input logic [1:0] f);
        instr = w;
        flags = f;
        pulse();
        pulse();
        pulse();
        @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R10 reset state
        chk(pc == 0 && sp == 0, "R10 pc/sp after reset", {pc[15:0], sp[15:0]}, 32'h0);
        chk(phase == 0 && status == 0, "R10 phase/status after reset", {phase, status}, 32'h0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            do_reset();
            run_instr(VECS[i].ins, VECS[i].fl);
            chk(pc == VECS[i].pc, $sformatf("R%0d vec %0d pc", VECS[i].req, i), pc, VECS[i].pc);
            chk(sp == VECS[i].sp, $sformatf("R%0d vec %0d sp", VECS[i].req, i), sp, VECS[i].sp);
            chk(status == VECS[i].st, $sformatf("R%0d vec %0d status", VECS[i].req, i), status, VECS[i].st);
        end

        // R1 phase rotation and hold
        do_reset();
        instr = 32'h0;
        pulse();
        chk(phase == 1, "R1 decode after one step", phase, 1);
        @(negedge clk);
        chk(phase == 1, "R1 hold without step", phase, 1);
        pulse();
        chk(phase == 2, "R1 execute", phase, 2);
        pulse();
        chk(phase == 0, "R1 back to fetch", phase, 0);
        chk(pc == 4, "R2 fetch added 4", pc, 4);

        // R4 and R5: call then return, with read timing
        do_reset();
        run_instr(32'h0F000100, 2'd0);
        run_instr(32'h11000040, 2'd0);
        chk(pc == 24'h40 && sp == 24'h106, "R4 call pc/sp", {pc[15:0], sp[15:0]}, 32'h00400106);
        chk(mem[8'h00] == 24'h8, "R4 pushed return address", mem[8'h00], 24'h8);
        instr = 32'h10000000;
        pulse();
        pulse();
        pulse();
        chk(pc == 24'h44 && phase == 2, "R5 pc not yet reloaded", {pc[15:0], 14'h0, phase}, 32'h00440002);
        chk(sp == 24'h100, "R5 sp lowered", sp, 24'h100);
        @(negedge clk);
        chk(pc == 24'h8 && phase == 0, "R5 pc reloaded next clock", {pc[15:0], 14'h0, phase}, 32'h00080000);

        // R5 nested calls unwind in order
        run_instr(32'h11000080, 2'd0);   // push 0x0C at 0x100
        run_instr(32'h11000090, 2'd0);   // push 0x84 at 0x106
        chk(sp == 24'h10C, "R4 nested sp", sp, 24'h10C);
        run_instr(32'h10000000, 2'd0);
        chk(pc == 24'h84 && sp == 24'h106, "R5 inner return", {pc[15:0], sp[15:0]}, 32'h00840106);
        run_instr(32'h10000000, 2'd0);
        chk(pc == 24'h0C && sp == 24'h100, "R5 outer return", {pc[15:0], sp[15:0]}, 32'h000C0100);

        // R8 call boundary, then R9 stickiness
        do_reset();
        run_instr(32'h0FFFFFF9, 2'd0);
        run_instr(32'h11000050, 2'd0);
        chk(pc == 24'h50 && sp == 24'hFFFFFF && status == 0, "R8 call at limit allowed",
            {pc[7:0], sp}, {8'h50, 24'hFFFFFF});
        chk(mem[8'hF9] == 24'h8, "R8 push at limit", mem[8'hF9], 24'h8);
        run_instr(32'h11000060, 2'd0);
        chk(status == 1, "R8 call above limit status", status, 1);
        chk(pc == 24'h54 && sp == 24'hFFFFFF, "R8 call above limit no change", {pc[7:0], sp}, {8'h54, 24'hFFFFFF});
        run_instr(32'h01000999, 2'd0);
        run_instr(32'h0F000000, 2'd0);
        chk(status == 1 && phase == 3, "R9 status held, halted", {status, phase}, {3'd1, 2'd3});
        chk(pc == 24'h54 && sp == 24'hFFFFFF, "R9 registers frozen", {pc[7:0], sp}, {8'h54, 24'hFFFFFF});

        // R8 return boundary: SP = 6 allowed, SP = 0 refused
        do_reset();
        mem[8'h00] = 24'h123456;
        run_instr(32'h0F000006, 2'd0);
        run_instr(32'h10000000, 2'd0);
        chk(pc == 24'h123456 && sp == 0 && status == 0, "R8 return at SP 6", pc, 24'h123456);
        run_instr(32'h10000000, 2'd0);
        chk(status == 1 && pc == 24'h12345A, "R8 return at SP 0 refused", {status, pc[23:0]}, {3'd1, 24'h12345A});

        // R7 decode error is raised on the decode step
        do_reset();
        instr = 32'h07000000;
        pulse();
        pulse();
        chk(status == 2 && phase == 3, "R7 error at decode step", {status, phase}, {3'd2, 2'd3});

        // R10 reset leaves the halt
        do_reset();
        chk(status == 0 && phase == 0 && pc == 0, "R10 reset clears fault", {status, phase}, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule